// File: doc/BRIEF.md
# Differential PWM Output Stage Sequencer

This block sits between a two-channel PWM modulator and the output pins. It decides, cycle by cycle, whether each channel's differential pair carries the modulator's bit stream, a silent waveform, or a fixed safe level. It also tells downstream logic when a channel's output can be trusted, and it enables or disables the clock sources. The input that selects between these cases is a small sequence of inputs: an asynchronous active-low reset, an active-low power input, an active-low mute request, and the modulator's frame strobe.

Reset and power-down force the safe level, in which the positive leg is held low, the negative leg is held high and the valid flag is low. When both reset and the power input are high, the block counts a bounded initialization window and then starts normal operation. A mute request does not stop the outputs. Both legs keep switching in phase at half duty, so the differential signal is zero and the valid flag stays high. Mute changes take effect only at a frame boundary, so no truncated pulse reaches the pins.

Top module: `pwm_outstage_ctrl`

## Requirements
- R1: Pulling `rst_n_i` low forces `out_p_o` to all zeros, `out_m_o` to all ones and `valid_o` to zero at once, with no clock edge needed.
- R2: While `rst_n_i` is low, the outputs stay at that safe level (P low, M high, valid low) whatever the modulator inputs do.
- R3: `pll_en_o` and `osc_en_o` equal `pwr_on_i` combinationally, so they react to it without a clock, in reset and out of it.
- R4: With `pwr_on_i` high, when `rst_n_i` is released between clock edges, `valid_o` goes high on the (INIT_CYCLES+4)-th rising edge after release. That count is two synchronizer stages, one state transition, INIT_CYCLES of initialization and one output register.
- R5: When `rst_n_i` is released while `pwr_on_i` is low, the block stays at the safe level with valid low. When `pwr_on_i` later rises, valid goes high on the (INIT_CYCLES+4)-th rising edge after that rise.
- R6: When `pwr_on_i` falls during normal operation, the outputs are at the safe level with valid low from the 4th rising edge on. When power returns, the block goes through initialization again and valid rises on the (INIT_CYCLES+4)-th edge.
- R7: While a mute is applied, `out_p_o` and `out_m_o` are equal on every channel. Both are high for frame positions 0 to FRAME_LEN/2-1 and low for the rest of the frame. Position 0 is the output value right after the edge that samples `frame_strobe_i` high. `valid_o` stays high throughout.
- R8: While unmuted in normal operation, the output after each rising edge equals the `mod_p_i`/`mod_m_i` values sampled at that edge.
- R9: `mute_n_i` passes through a two-flop synchronizer and acts only at the edge where `frame_strobe_i` is sampled high. A change made in the middle of a frame leaves the rest of that frame unchanged. The new mode holds from position 0 of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Modulator clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| pwr_on_i | input | 1 | Power input; low requests power-down |
| mute_n_i | input | 1 | Active-low mute request, asynchronous |
| frame_strobe_i | input | 1 | High for one cycle at the first position of each PWM frame |
| mod_p_i | input | NCH | Modulator positive-leg bits, one per channel |
| mod_m_i | input | NCH | Modulator negative-leg bits, one per channel |
| out_p_o | output | NCH | Positive-leg output pins |
| out_m_o | output | NCH | Negative-leg output pins |
| valid_o | output | NCH | Per-channel output-valid flags |
| pll_en_o | output | 1 | PLL enable |
| osc_en_o | output | 1 | Oscillator enable |

## Verification
The bench builds the block with two channels, an 8-cycle frame and an INIT_CYCLES of 24 instead of the default 5 ms count. This makes the initialization window short enough to measure to the exact edge several times in one run: after a reset, after a power-down with reset held, and after a power loss while running. The short frame lets the bench check whole quiet-mute frames position by position. It also lets it place a mute change at a known frame position and confirm that the change takes effect only at the next boundary.

// File: rtl/pwmo_pkg.sv
package pwmo_pkg;

  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_INIT = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_t;

  // Silent waveform: high during the first half of a frame.
  function automatic logic quiet_level(input int unsigned pos, input int unsigned frame_len);
    return pos < (frame_len / 2);
  endfunction

  // True on the final initialization cycle.
  function automatic logic init_last(input int unsigned cnt, input int unsigned limit);
    return cnt == (limit - 1);
  endfunction

  // Next {P, M} value for one lane.
  function automatic logic [1:0] drive_pair(input logic run, input logic mute,
                                            input logic quiet, input logic p,
                                            input logic m);
    if (!run)      return 2'b01;
    else if (mute) return {quiet, quiet};
    else           return {p, m};
  endfunction

endpackage

// File: rtl/pwmo_sync.sv
module pwmo_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         arst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/pwmo_seq.sv
module pwmo_seq
  import pwmo_pkg::*;
#(
  parameter int INIT_CYCLES = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_ok_i,
  output logic run_o,
  output logic init_o
);
  localparam int CW = $clog2(INIT_CYCLES + 1);

  seq_state_t    state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_HOLD: begin
          if (pwr_ok_i) begin
            state_q <= ST_INIT;
            cnt_q   <= '0;
          end
        end
        ST_INIT: begin
          if (!pwr_ok_i) begin
            state_q <= ST_HOLD;
          end else if (init_last(32'(cnt_q), INIT_CYCLES)) begin
            state_q <= ST_RUN;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_RUN: begin
          if (!pwr_ok_i) state_q <= ST_HOLD;
        end
        default: state_q <= ST_HOLD;
      endcase
    end
  end

  assign run_o  = (state_q == ST_RUN);
  assign init_o = (state_q == ST_INIT);
endmodule

// File: rtl/pwmo_frame.sv
module pwmo_frame
  import pwmo_pkg::*;
#(
  parameter int FRAME_LEN = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic mute_req_i,
  output logic quiet_o,
  output logic mute_next_o,
  output logic mute_q_o
);
  localparam int PW = $clog2(FRAME_LEN + 1);

  logic [PW-1:0] ph_q;
  logic [PW-1:0] pos;
  logic          mute_q;

  // Position of the cycle being captured now; the strobe marks position 0.
  assign pos         = strobe_i ? '0 : ph_q;
  assign quiet_o     = quiet_level(32'(pos), FRAME_LEN);
  assign mute_next_o = strobe_i ? mute_req_i : mute_q;
  assign mute_q_o    = mute_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PW'(FRAME_LEN);
      mute_q <= 1'b1;
    end else begin
      if (strobe_i)                    ph_q <= PW'(1);
      else if (ph_q != PW'(FRAME_LEN)) ph_q <= ph_q + PW'(1);
      mute_q <= mute_next_o;
    end
  end
endmodule

// File: rtl/pwmo_lane.sv
module pwmo_lane
  import pwmo_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic mute_i,
  input  logic quiet_i,
  input  logic mod_p_i,
  input  logic mod_m_i,
  output logic out_p_o,
  output logic out_m_o,
  output logic valid_o
);
  logic [1:0] pair_d;

  assign pair_d = drive_pair(run_i, mute_i, quiet_i, mod_p_i, mod_m_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_p_o <= 1'b0;
      out_m_o <= 1'b1;
      valid_o <= 1'b0;
    end else begin
      out_p_o <= pair_d[1];
      out_m_o <= pair_d[0];
      valid_o <= run_i;
    end
  end
endmodule

// File: rtl/pwm_outstage_ctrl.sv
module pwm_outstage_ctrl
  import pwmo_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int FRAME_LEN   = 256,
  parameter int INIT_CYCLES = 250000
) (
  input  logic           clk_i,
  input  logic           rst_n_i,
  input  logic           pwr_on_i,
  input  logic           mute_n_i,
  input  logic           frame_strobe_i,
  input  logic [NCH-1:0] mod_p_i,
  input  logic [NCH-1:0] mod_m_i,
  output logic [NCH-1:0] out_p_o,
  output logic [NCH-1:0] out_m_o,
  output logic [NCH-1:0] valid_o,
  output logic           pll_en_o,
  output logic           osc_en_o
);
  // Named internal events, observed by the bound checker.
  logic       rst_sync_n;
  logic [1:0] ctl_sync;
  logic       pwr_ok;
  logic       mute_req;
  logic       run_q;
  logic       init_busy;
  logic       quiet_lvl;
  logic       mute_next;
  logic       mute_q;

  // Clock sources follow the power input with no register.
  assign pll_en_o = pwr_on_i;
  assign osc_en_o = pwr_on_i;

  pwmo_sync #(.W(1), .RST_VAL(1'b0)) u_rst_sync (
    .clk_i   (clk_i),
    .arst_ni (rst_n_i),
    .d_i     (1'b1),
    .q_o     (rst_sync_n)
  );

  pwmo_sync #(.W(2), .RST_VAL(2'b00)) u_ctl_sync (
    .clk_i   (clk_i),
    .arst_ni (rst_n_i),
    .d_i     ({pwr_on_i, mute_n_i}),
    .q_o     (ctl_sync)
  );

  assign pwr_ok   = ctl_sync[1];
  assign mute_req = ~ctl_sync[0];

  pwmo_seq #(.INIT_CYCLES(INIT_CYCLES)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .pwr_ok_i (pwr_ok),
    .run_o    (run_q),
    .init_o   (init_busy)
  );

  pwmo_frame #(.FRAME_LEN(FRAME_LEN)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .strobe_i    (frame_strobe_i),
    .mute_req_i  (mute_req),
    .quiet_o     (quiet_lvl),
    .mute_next_o (mute_next),
    .mute_q_o    (mute_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    pwmo_lane u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_sync_n),
      .run_i   (run_q),
      .mute_i  (mute_next),
      .quiet_i (quiet_lvl),
      .mod_p_i (mod_p_i[c]),
      .mod_m_i (mod_m_i[c]),
      .out_p_o (out_p_o[c]),
      .out_m_o (out_m_o[c]),
      .valid_o (valid_o[c])
    );
  end
endmodule

// File: rtl/pwmo_checker.sv
module pwmo_checker #(
  parameter int NCH         = 2,
  parameter int INIT_CYCLES = 250000
) (
  input logic           clk_i,
  input logic           rst_n_i,
  input logic           pwr_ok,
  input logic           run_q,
  input logic           init_busy,
  input logic           mute_q,
  input logic           frame_strobe_i,
  input logic [NCH-1:0] mod_p_i,
  input logic [NCH-1:0] mod_m_i,
  input logic [NCH-1:0] out_p_o,
  input logic [NCH-1:0] out_m_o,
  input logic [NCH-1:0] valid_o
);
  int unsigned init_seen;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)       init_seen <= 0;
    else if (init_busy) init_seen <= init_seen + 1;
    else                init_seen <= 0;
  end

  // R2: safe level during reset
  always @(negedge clk_i) begin
    if (!rst_n_i) begin
      a_r2_hard_mute: assert (out_p_o == '0 && out_m_o == '1 && valid_o == '0);
    end
  end

  // R4: initialization never runs past its bound
  a_r4_init_bound: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    init_busy |-> (init_seen < INIT_CYCLES));

  // R4: valid rises only after initialization
  a_r4_run_follows_init: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(valid_o[0]) |-> $past(init_busy, 2));

  // R6: power loss stops normal operation
  a_r6_pdown_stops_run: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !pwr_ok |=> !run_q);

  // R7: quiet mute keeps both legs in phase
  a_r7_quiet_in_phase: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (valid_o[0] && mute_q) |-> (out_p_o == out_m_o));

  // R8: unmuted outputs follow the modulator by one edge
  a_r8_pass_through: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (valid_o[0] && !mute_q) |-> (out_p_o == $past(mod_p_i) && out_m_o == $past(mod_m_i)));

  // R9: mute mode changes only at a frame strobe
  a_r9_boundary_only: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !frame_strobe_i |=> $stable(mute_q));
endmodule

bind pwm_outstage_ctrl pwmo_checker #(.NCH(NCH), .INIT_CYCLES(INIT_CYCLES)) u_pwmo_checker (
  .clk_i          (clk_i),
  .rst_n_i        (rst_n_i),
  .pwr_ok         (pwr_ok),
  .run_q          (run_q),
  .init_busy      (init_busy),
  .mute_q         (mute_q),
  .frame_strobe_i (frame_strobe_i),
  .mod_p_i        (mod_p_i),
  .mod_m_i        (mod_m_i),
  .out_p_o        (out_p_o),
  .out_m_o        (out_m_o),
  .valid_o        (valid_o)
);

// File: tb/test_pwm_outstage_ctrl.sv
module test_pwm_outstage_ctrl;
  localparam int NCH = 2;
  localparam int FL = 8;
  localparam int IC = 24;
  localparam int HALF = FL / 2;
  localparam int INIT_LAT = IC + 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b1, pwr_on = 1'b1, mute_n = 1'b1, strobe = 1'b0;
  logic [NCH-1:0] mod_p = '0, mod_m = '0;
  wire  [NCH-1:0] out_p, out_m, valid;
  wire            pll_en, osc_en;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  pwm_outstage_ctrl #(.NCH(NCH), .FRAME_LEN(FL), .INIT_CYCLES(IC)) i_pwm_outstage_ctrl (
    .clk_i(clk), .rst_n_i(rst_n), .pwr_on_i(pwr_on), .mute_n_i(mute_n),
    .frame_strobe_i(strobe), .mod_p_i(mod_p), .mod_m_i(mod_m),
    .out_p_o(out_p), .out_m_o(out_m), .valid_o(valid),
    .pll_en_o(pll_en), .osc_en_o(osc_en)
  );

  // Stimulus: records what the last rising edge sampled, then drives new values.
  int fc = 0;
  int app_pos = FL;
  logic [7:0] lfsr = 8'h5a;
  logic [NCH-1:0] app_p = '0, app_m = '0;

  always @(negedge clk) begin
    app_p = mod_p;
    app_m = mod_m;
    app_pos = strobe ? 0 : app_pos + 1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mod_p = lfsr[1:0];
    mod_m = lfsr[4:3];
    strobe = (fc == 0);
    fc = (fc == FL - 1) ? 0 : fc + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_pos(input int p);
    do tick(); while (app_pos != p);
  endtask

  task automatic chk_safe(input string req);
    chk(out_p == '0 && out_m == '1 && valid == '0, req,
        int'({out_p, out_m, valid}), int'({2'b00, 2'b11, 2'b00}));
  endtask

  task automatic chk_pass(input string req);
    chk(out_p == app_p && out_m == app_m && valid == '1, req,
        int'({out_p, out_m}), int'({app_p, app_m}));
  endtask

  task automatic chk_quiet(input string req);
    logic [NCH-1:0] e;
    e = (app_pos < HALF) ? '1 : '0;
    chk(out_p == e && out_m == e && valid == '1, req,
        int'({out_p, out_m, valid}), int'({e, e, 2'b11}));
  endtask

  // Called just after a release that happens between edges.
  task automatic measure_init(input string req);
    int n = 0;
    while (n < INIT_LAT + 20) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      #1;
      if (valid == '1) break;
    end
    chk(n == INIT_LAT, req, n, INIT_LAT);
  endtask

  task automatic t_reset_state();
    repeat (5) begin
      tick();
      chk_safe("R2");
    end
    chk(pll_en == 1'b1 && osc_en == 1'b1, "R3", int'({pll_en, osc_en}), 3);
  endtask

  task automatic t_init();
    rst_n = 1'b1;
    measure_init("R4");
  endtask

  task automatic t_pass();
    repeat (FL + 1) tick();
    wait_pos(0);
    for (int k = 0; k < 2 * FL; k++) begin
      chk_pass("R8");
      tick();
    end
  endtask

  task automatic t_quiet();
    mute_n = 1'b0;
    repeat (3) tick();
    wait_pos(0);
    for (int k = 0; k < 2 * FL; k++) begin
      chk_quiet("R7");
      tick();
    end
  endtask

  task automatic t_unmute_mid();
    wait_pos(2);
    mute_n = 1'b1;
    repeat (FL - 3) begin
      tick();
      chk_quiet("R9");
    end
    repeat (FL) begin
      tick();
      chk_pass("R9");
    end
  endtask

  task automatic t_mute_mid();
    wait_pos(2);
    mute_n = 1'b0;
    repeat (FL - 3) begin
      tick();
      chk_pass("R9");
    end
    repeat (FL) begin
      tick();
      chk_quiet("R9");
    end
    mute_n = 1'b1;
    repeat (2 * FL) tick();
  endtask

  task automatic t_async_reset();
    wait_pos(3);
    #3 rst_n = 1'b0;
    #1 chk_safe("R1");
    repeat (6) begin
      tick();
      chk_safe("R2");
    end
    rst_n = 1'b1;
    measure_init("R4");
  endtask

  task automatic t_pdown_full();
    rst_n = 1'b0;
    #2 pwr_on = 1'b0;
    #1 chk(pll_en == 1'b0 && osc_en == 1'b0, "R3", int'({pll_en, osc_en}), 0);
    tick();
    chk_safe("R2");
    rst_n = 1'b1;
    repeat (IC + 10) begin
      tick();
      chk_safe("R5");
    end
    pwr_on = 1'b1;
    #1 chk(pll_en == 1'b1 && osc_en == 1'b1, "R3", int'({pll_en, osc_en}), 3);
    measure_init("R5");
  endtask

  task automatic t_pdown_run();
    repeat (FL) tick();
    pwr_on = 1'b0;
    #1 chk(pll_en == 1'b0 && osc_en == 1'b0, "R3", int'({pll_en, osc_en}), 0);
    repeat (4) tick();
    chk_safe("R6");
    repeat (5) begin
      tick();
      chk_safe("R6");
    end
    pwr_on = 1'b1;
    measure_init("R6");
  endtask

  initial begin
    #1 rst_n = 1'b0;
    t_reset_state();
    t_init();
    t_pass();
    t_quiet();
    t_unmute_mid();
    t_mute_mid();
    t_async_reset();
    t_pass();
    t_pdown_full();
    t_pass();
    t_pdown_run();
    t_pass();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule